// File: doc/BRIEF.md
# Presettable Binary Up Counter with Chain Carry

This block is a small binary up counter, four bits wide by default, that advances on the rising clock edge. It can be preset from a parallel input through an active-low load. It can be cleared by an active-low reset, and a build-time parameter makes that reset act either at once or only at the next rising edge. Counting needs two enables, a hold enable and a chain enable. Only the chain enable also gates the carry output.

The carry output is high when the count holds its largest value and the chain enable is high. Stages share one clock. The carry of each stage drives the chain enable of the next, so several stages make one wider synchronous counter. When the reset acts on the clock edge, decoding a chosen count onto the reset pin gives a counter of any modulus with no brief extra state.

Top module: `presettable_upcounter`

## Requirements
- R1: When counting is enabled, each rising edge adds one to `count` in plain binary. `count[0]` is the least significant bit. From 15 (4'b1111) the count goes to 0.
- R2: `rstN` low forces `count` to 0. With `RESET_SYNC`=0 the clear takes effect at once, without a clock edge. With `RESET_SYNC`=1 it takes effect only at the next rising edge, and `count` holds its value until then.
- R3: A rising edge with `loadN` low copies `preset` into `count`, bit for bit with `preset[0]` going to `count[0]`. Counting is suppressed while `loadN` is low, whatever the enables are.
- R4: The counter advances only when `enCount`, `enChain` and `loadN` are all high. If either enable is low with `loadN` high, `count` keeps its value.
- R5: `carryOut` is high exactly when `enChain` is high and `count` is 15. It follows the registered count in the same cycle, with no extra register.
- R6: `enCount` and `loadN` have no effect on `carryOut`. `enChain` low forces `carryOut` low.
- R7: Reset has priority over load, and load has priority over counting.
- R8: Two stages on one clock, with the first stage's `carryOut` driving the second stage's `enChain`, count as one 8-bit counter (first stage low nibble). This counter goes from 255 to 0.
- R9: With `RESET_SYNC`=1, driving `rstN` low when the count equals N-1 gives a counter that steps through exactly the N states 0 to N-1 and shows no other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low clear (immediate or edge-timed by `RESET_SYNC`) |
| loadN | input | 1 | Active-low synchronous parallel load |
| enCount | input | 1 | Count enable that does not affect the carry |
| enChain | input | 1 | Count enable that also gates `carryOut` |
| preset | input | WIDTH | Parallel load value, bit 0 least significant |
| count | output | WIDTH | Current count, bit 0 least significant |
| carryOut | output | 1 | High when count is at maximum and `enChain` is high |

## Verification
The clocked properties assume that every control input is stable and free of X around each rising edge. When `RESET_SYNC`=1 they also assume that the reset is seen only at edges. The bench changes the controls one time unit after a rising edge and samples the outputs one time unit after the next edge, so no input changes near an edge.

The one planned exception is the immediate-reset check. There the bench pulls `rstN` low in the middle of a cycle, because R2 is about exactly that case. The modulus counter drives its own reset from its count. This is allowed, because the decode settles long before the next edge.

// File: rtl/upcnt_pkg.sv
package upcnt_pkg;

  // Strobes issued by the control unit to the count register for one edge
  typedef struct packed {
    logic clear;  // edge-timed clear (synchronous reset mode only)
    logic load;   // copy the preset word
    logic inc;    // add one
  } cnt_strobe_t;

endpackage

// File: rtl/upcnt_ctrl.sv
module upcnt_ctrl
  import upcnt_pkg::*;
#(
  parameter bit RESET_SYNC = 1'b0
) (
  input  logic        rstN,
  input  logic        loadN,
  input  logic        enCount,
  input  logic        enChain,
  output cnt_strobe_t strobe
);

  logic clearReq;

  // In immediate-reset mode the clear bypasses the strobes entirely.
  assign clearReq = RESET_SYNC ? ~rstN : 1'b0;

  // Fixed priority: clear over load over increment.
  always_comb begin
    strobe.clear = clearReq;
    strobe.load  = ~clearReq & ~loadN;
    strobe.inc   = ~clearReq & loadN & enCount & enChain;
  end

endmodule

// File: rtl/upcnt_datapath.sv
module upcnt_datapath
  import upcnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit RESET_SYNC = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strobe,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] countNext;

  always_comb begin
    countNext = count;
    if (strobe.clear)      countNext = '0;
    else if (strobe.load)  countNext = preset;
    else if (strobe.inc)   countNext = count + WIDTH'(1);
  end

  generate
    if (RESET_SYNC) begin : g_syncClear
      always_ff @(posedge clk) begin
        count <= countNext;
      end
    end else begin : g_asyncClear
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) count <= '0;
        else       count <= countNext;
      end
    end
  endgenerate

endmodule

// File: rtl/upcnt_carry.sv
module upcnt_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             enChain,
  output logic             carryOut
);

  // Combinational so a following stage sees it in the same cycle.
  assign carryOut = enChain & (&count);

endmodule

// File: rtl/presettable_upcounter.sv
module presettable_upcounter
  import upcnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit RESET_SYNC = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic             enCount,
  input  logic             enChain,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  cnt_strobe_t strobe;

  upcnt_ctrl #(.RESET_SYNC(RESET_SYNC)) uCtrl (
    .rstN    (rstN),
    .loadN   (loadN),
    .enCount (enCount),
    .enChain (enChain),
    .strobe  (strobe)
  );

  upcnt_datapath #(.WIDTH(WIDTH), .RESET_SYNC(RESET_SYNC)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .preset (preset),
    .count  (count)
  );

  upcnt_carry #(.WIDTH(WIDTH)) uCarry (
    .count    (count),
    .enChain  (enChain),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/upcnt_checker.sv
module upcnt_checker #(
  parameter int WIDTH      = 4,
  parameter bit RESET_SYNC = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadN,
  input logic             enCount,
  input logic             enChain,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             carryOut
);

  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  // R1 / R4: enabled counting adds one, wrapping at the top
  a_r1_increment: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && enCount && enChain) |=> count == WIDTH'($past(count) + 1'b1));

  // R4: a low enable holds the count
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !(enCount && enChain)) |=> $stable(count));

  // R3 / R7: load beats counting
  a_r3_load: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN) |=> count == $past(preset));

  // R2 / R7: a reset seen at an edge leaves zero behind, in both modes
  a_r2_clear: assert property (@(posedge clk) disable iff (!seenEdge)
    (!rstN) |=> count == '0);

  // R6: chain enable low keeps the carry low
  a_r6_carry_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!enChain) |-> !carryOut);

  // R5: carry only at the maximum count
  a_r5_carry_max: assert property (@(posedge clk) disable iff (!rstN)
    carryOut |-> (&count));

endmodule

bind presettable_upcounter upcnt_checker #(.WIDTH(WIDTH), .RESET_SYNC(RESET_SYNC)) uChk (.*);

// File: tb/tb_presettable_upcounter.sv
module tb_presettable_upcounter;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // shared stimulus for the immediate-reset (dut) and edge-reset (dutS) units
  logic       rstN = 1'b0, loadN = 1'b1, enCount = 1'b0, enChain = 1'b0;
  logic [3:0] preset = 4'h0;
  logic [3:0] cntA, cntS;
  logic       coA, coS;

  presettable_upcounter #(.WIDTH(4), .RESET_SYNC(1'b0)) dut (
    .clk(clk), .rstN(rstN), .loadN(loadN), .enCount(enCount), .enChain(enChain),
    .preset(preset), .count(cntA), .carryOut(coA));

  presettable_upcounter #(.WIDTH(4), .RESET_SYNC(1'b1)) dutS (
    .clk(clk), .rstN(rstN), .loadN(loadN), .enCount(enCount), .enChain(enChain),
    .preset(preset), .count(cntS), .carryOut(coS));

  // two chained stages (R8)
  logic       chLoadN = 1'b1;
  logic [3:0] loCnt, hiCnt;
  logic       loCo, hiCo;

  presettable_upcounter #(.WIDTH(4), .RESET_SYNC(1'b1)) uLo (
    .clk(clk), .rstN(rstN), .loadN(chLoadN), .enCount(1'b1), .enChain(1'b1),
    .preset(4'hA), .count(loCnt), .carryOut(loCo));

  presettable_upcounter #(.WIDTH(4), .RESET_SYNC(1'b1)) uHi (
    .clk(clk), .rstN(rstN), .loadN(chLoadN), .enCount(1'b1), .enChain(loCo),
    .preset(4'hF), .count(hiCnt), .carryOut(hiCo));

  // modulus-6 counter through decoded edge-timed reset (R9)
  localparam int MODN = 6;
  logic       modClr = 1'b1;
  logic [3:0] modCnt;
  logic       modCo;
  logic       modRstN;
  assign modRstN = ~modClr & (modCnt != 4'(MODN - 1));

  presettable_upcounter #(.WIDTH(4), .RESET_SYNC(1'b1)) uMod (
    .clk(clk), .rstN(modRstN), .loadN(1'b1), .enCount(1'b1), .enChain(1'b1),
    .preset(4'h0), .count(modCnt), .carryOut(modCo));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // vector: {rstN, loadN, enCount, enChain, preset[3:0], expCount[3:0], expCarry}
  localparam int NVEC = 14;
  localparam logic [12:0] VEC [NVEC] = '{
    13'b1_0_1_1_1101_1101_0,  // R3 load 13
    13'b1_1_1_1_0000_1110_0,  // R1 -> 14
    13'b1_1_1_1_0000_1111_1,  // R1/R5 -> 15 carry
    13'b1_1_0_1_0000_1111_1,  // R4/R6 enCount low holds, carry stays
    13'b1_1_1_0_0000_1111_0,  // R4/R6 enChain low holds, carry low
    13'b1_0_1_1_1111_1111_1,  // R6 load low does not drop carry
    13'b1_1_1_1_0000_0000_0,  // R1 wrap 15 -> 0
    13'b1_1_1_1_0000_0001_0,  // R1 -> 1
    13'b1_0_1_1_1010_1010_0,  // R7 load beats count
    13'b0_0_1_1_0101_0000_0,  // R7 reset beats load
    13'b1_1_0_0_0000_0000_0,  // R4 both enables low
    13'b1_1_1_1_0000_0001_0,  // R1 -> 1
    13'b1_0_0_0_0110_0110_0,  // R3 load with enables low
    13'b1_1_1_1_0000_0111_0   // R1 -> 7
  };

  initial begin
    // reset state
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset state async", {4'h0, cntA}, 8'd0);
    check("R2 reset state sync", {4'h0, cntS}, 8'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      {rstN, loadN, enCount, enChain, preset} = VEC[i][12:5];
      @(posedge clk);
      #1;
      check($sformatf("R1-table vec%0d count async", i), {4'h0, cntA}, {4'h0, VEC[i][4:1]});
      check($sformatf("R3-table vec%0d count sync", i), {4'h0, cntS}, {4'h0, VEC[i][4:1]});
      check($sformatf("R5 vec%0d carry", i), {7'h0, coA}, {7'h0, VEC[i][0]});
      check($sformatf("R6 vec%0d carry sync", i), {7'h0, coS}, {7'h0, VEC[i][0]});
    end

    // R2: mid-cycle reset, both at 7 now
    enCount = 1'b0; enChain = 1'b0; loadN = 1'b1;
    #0.5;
    rstN = 1'b0;
    #0.5;
    check("R2 immediate clear", {4'h0, cntA}, 8'd0);
    check("R2 edge clear waits", {4'h0, cntS}, 8'd7);
    @(posedge clk);
    #1;
    check("R2 edge clear applied", {4'h0, cntS}, 8'd0);
    rstN = 1'b1;

    // R5: carry is combinational from enChain
    loadN = 1'b0; preset = 4'hF;
    @(posedge clk);
    #1;
    loadN = 1'b1; enChain = 1'b1;
    #0.5;
    check("R5 carry same cycle", {7'h0, coA}, 8'd1);
    enChain = 1'b0;
    #0.5;
    check("R6 carry gated", {7'h0, coA}, 8'd0);

    // R8: chained pair from 250 through 255 to 0
    chLoadN = 1'b0;
    @(posedge clk);
    #1;
    chLoadN = 1'b1;
    check("R8 chain load", {hiCnt, loCnt}, 8'd250);
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk);
      #1;
      check($sformatf("R8 chain step %0d", k), {hiCnt, loCnt}, 8'((250 + k) % 256));
      check($sformatf("R8 chain carry %0d", k), {7'h0, hiCo},
            {7'h0, ((250 + k) % 256) == 255});
    end

    // R9: modulus-6 sequence
    modClr = 1'b1;
    @(posedge clk);
    #1;
    modClr = 1'b0;
    check("R9 mod start", {4'h0, modCnt}, 8'd0);
    for (int k = 1; k <= 2 * MODN + 1; k++) begin
      @(posedge clk);
      #1;
      check($sformatf("R9 mod step %0d", k), {4'h0, modCnt}, 8'(k % MODN));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule